// File: doc/BRIEF.md
# Two-Level Router Output Buffer

This block holds the flits that a five-port mesh router has already switched and that wait for their output links (East, South, West, North and the local processor). Each output owns a small private queue whose head is presented to the downstream router. A flit normally lands in the private queue of its output. When that queue is full, or when the output's congestion flag is high, the flit is placed in a common overflow pool instead. The pool is shared by all five outputs and keeps one linked list per output, so any free slot can serve any output.

Whenever a downstream router takes the head flit of a private queue, the oldest pooled flit for that output moves into the private queue in the same cycle. A pooled flit also moves across when the private queue has room and the output is not congested. The pool's head pointer for that output then advances to the next flit in the list. When an output already has flits in the pool, its new flits are also pooled, so each output delivers its flits in the order they arrived. A per-output two-state controller tracks this. In DIRECT mode no flits are pooled for the output. In SPILL mode at least one is. The controller moves from DIRECT to SPILL on the transition "enter spill", when a flit for the output is written to the pool. It moves from SPILL back to DIRECT on the transition "drain", when the last pooled flit for the output moves to the private queue and no new flit for that output is pooled in the same cycle. When a flit has to go to the pool and the pool has no free slot, the block raises a stall towards the input side.

Top module: `two_level_obuf`

## Requirements
- R1: After reset every private queue and the pool are empty, all `out_valid` bits are 0, every output is in DIRECT mode, and `in_stall` is 0.
- R2: `in_dest` selects the output: 0 East, 1 South, 2 West, 3 North, 4 processor. Output k appears on `out_valid[k]` and on `out_data[k*W +: W]`. A flit with `in_dest` 5, 6 or 7 is dropped. It raises no stall and appears on no output.
- R3: A flit goes straight into its output's private queue when all three of these hold: the queue has fewer than 2 entries, `cong` for that output is 0, and the pool holds no flit for that output. It is visible at the output from the cycle after it is accepted.
- R4: A private queue holds at most 2 flits. A flit for an output whose private queue already holds 2 flits goes to the pool.
- R5: While `cong[k]` is 1, new flits for output k go to the pool even if its private queue has room. No pooled flit moves into that queue unless the downstream router takes a flit.
- R6: While the pool holds a flit for output k, every new flit for k goes to the pool. Each output delivers its flits in acceptance order.
- R7: `rd_req[k]` together with `out_valid[k]` removes the head flit of output k at the clock edge. `rd_req[k]` while `out_valid[k]` is 0 has no effect.
- R8: At the edge where output k's head is taken, the oldest pooled flit for k moves into k's private queue. The same move also happens at any edge where the queue has fewer than 2 entries and `cong[k]` is 0.
- R9: The pool's slots are shared by all outputs. Any number of outputs may take a pooled flit in the same cycle as one flit is written to the pool.
- R10: `in_stall` is 1 exactly when three things hold: `in_valid` is 1 with a destination of 0 to 4, the flit would go to the pool, and all POOL_DEPTH slots are occupied. A stalled flit is not accepted.
- R11: While `out_valid[k]` is 1 and `rd_req[k]` is 0, `out_valid[k]` stays 1 and `out_data[k*W +: W]` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A switched flit is offered this cycle |
| in_dest | input | 3 | Output index of the offered flit |
| in_data | input | W | Offered flit |
| in_stall | output | 1 | Offered flit not taken: pool full |
| cong | input | 5 | Per-output congestion level |
| rd_req | input | 5 | Per-output downstream request |
| out_valid | output | 5 | Per-output head flit present |
| out_data | output | 5*W | Per-output head flit, output k in bits k*W +: W |

## Verification
The bench aims at the cycle in which a pop, a refill and a pool write all hit the same output. Here a list holding one flit must hand its head to the new flit. A wrong pointer update would lose the new flit or send the old one twice. It fills the pool to its last slot with a congested output. It then checks that only flits that need the pool stall, while a flit with room in its private queue still passes. A stall tied only to the full condition would block that flit. Congestion is switched on and off while flits are pooled. This checks that no out-of-order bypass into the private queue happens, which a design deciding only on queue fullness would allow. Invalid destination codes are offered to confirm that nothing reaches any output.

// File: rtl/tlob_pkg.sv
package tlob_pkg;

    localparam int NPORT = 5;
    localparam int DESTW = 3;

    typedef enum logic [2:0] {
        PORT_EAST  = 3'd0,
        PORT_SOUTH = 3'd1,
        PORT_WEST  = 3'd2,
        PORT_NORTH = 3'd3,
        PORT_PROC  = 3'd4
    } port_e;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_SPILL  = 1'b1
    } mode_e;

endpackage

// File: rtl/tlob_l1q.sv
module tlob_l1q #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         valid,
    output logic         full,
    output logic [W-1:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot_q [DEPTH];
    logic [AW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] fill_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign valid = (fill_q != '0);
    assign full  = (fill_q == CW'(DEPTH));
    assign head  = slot_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            fill_q   <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            if (push && !pop)      fill_q <= fill_q + CW'(1);
            else if (pop && !push) fill_q <= fill_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[wr_ptr_q] <= push_data;
    end

endmodule

// File: rtl/tlob_pool.sv
module tlob_pool #(
    parameter int W     = 8,
    parameter int NP    = 5,
    parameter int PW    = 3,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PW-1:0]   wr_port,
    input  logic [W-1:0]    wr_data,
    input  logic [NP-1:0]   rd_en,
    output logic [NP-1:0]   has_data,
    output logic [NP-1:0]   last_one,
    output logic [NP*W-1:0] head_data,
    output logic            full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]     cell_q [DEPTH];
    logic [AW-1:0]    next_q [DEPTH];
    logic [DEPTH-1:0] busy_q, busy_d;
    logic [AW-1:0]    first_q [NP];
    logic [AW-1:0]    last_q  [NP];
    logic [CW-1:0]    len_q   [NP];
    logic [AW-1:0]    alloc;

    // lowest free slot
    always_comb begin
        alloc = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy_q[i]) alloc = AW'(i);
        end
    end

    assign full = &busy_q;

    generate
        for (genvar p = 0; p < NP; p++) begin : g_view
            assign has_data[p]          = (len_q[p] != '0);
            assign last_one[p]          = (len_q[p] == CW'(1));
            assign head_data[p*W +: W]  = cell_q[first_q[p]];
        end
    endgenerate

    always_comb begin
        busy_d = busy_q;
        for (int p = 0; p < NP; p++) begin
            if (rd_en[p]) busy_d[first_q[p]] = 1'b0;
        end
        if (wr_en) busy_d[alloc] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            for (int p = 0; p < NP; p++) begin
                first_q[p] <= '0;
                last_q[p]  <= '0;
                len_q[p]   <= '0;
            end
        end else begin
            busy_q <= busy_d;
            for (int p = 0; p < NP; p++) begin
                if (rd_en[p] && wr_en && wr_port == PW'(p)) begin
                    first_q[p] <= (len_q[p] == CW'(1)) ? alloc : next_q[first_q[p]];
                    last_q[p]  <= alloc;
                end else if (rd_en[p]) begin
                    first_q[p] <= next_q[first_q[p]];
                    len_q[p]   <= len_q[p] - CW'(1);
                end else if (wr_en && wr_port == PW'(p)) begin
                    if (len_q[p] == '0) first_q[p] <= alloc;
                    last_q[p] <= alloc;
                    len_q[p]  <= len_q[p] + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) cell_q[alloc] <= wr_data;
        for (int p = 0; p < NP; p++) begin
            if (wr_en && wr_port == PW'(p) && len_q[p] != '0)
                next_q[last_q[p]] <= alloc;
        end
    end

endmodule

// File: rtl/tlob_dispatch.sv
module tlob_dispatch
    import tlob_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DESTW-1:0] in_dest,
    input  logic [NPORT-1:0] cong,
    input  logic [NPORT-1:0] rd_req,
    input  logic [NPORT-1:0] l1_valid,
    input  logic [NPORT-1:0] l1_full,
    input  logic             pool_full,
    input  logic [NPORT-1:0] pool_last,
    output logic             in_stall,
    output logic [NPORT-1:0] l1_pop,
    output logic [NPORT-1:0] l1_push,
    output logic [NPORT-1:0] refill,
    output logic             pool_wr,
    output logic [NPORT-1:0] spill_mode
);
    mode_e            mode_q [NPORT];
    mode_e            mode_d [NPORT];
    logic [NPORT-1:0] sel, direct;
    logic             dest_ok, wants_pool;

    always_comb begin
        dest_ok = (in_dest <= PORT_PROC);
        for (int p = 0; p < NPORT; p++) begin
            sel[p]        = dest_ok && (in_dest == DESTW'(p));
            spill_mode[p] = (mode_q[p] == MODE_SPILL);
            l1_pop[p]     = rd_req[p] && l1_valid[p];
            refill[p]     = spill_mode[p] && (l1_pop[p] || (!l1_full[p] && !cong[p]));
            direct[p]     = sel[p] && !l1_full[p] && !cong[p] && !spill_mode[p];
        end
        wants_pool = in_valid && dest_ok && (direct == '0);
        in_stall   = wants_pool && pool_full;
        pool_wr    = wants_pool && !pool_full;
        for (int p = 0; p < NPORT; p++) begin
            l1_push[p] = refill[p] || (in_valid && direct[p]);
        end
    end

    // per-output mode: enter spill / drain
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            mode_d[p] = mode_q[p];
            unique case (mode_q[p])
                MODE_DIRECT: if (pool_wr && sel[p]) mode_d[p] = MODE_SPILL;
                MODE_SPILL:  if (refill[p] && pool_last[p] && !(pool_wr && sel[p]))
                                 mode_d[p] = MODE_DIRECT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            if (!rst_n) mode_q[p] <= MODE_DIRECT;
            else        mode_q[p] <= mode_d[p];
        end
    end

endmodule

// File: rtl/two_level_obuf.sv
module two_level_obuf
    import tlob_pkg::*;
#(
    parameter int W          = 8,
    parameter int L1_DEPTH   = 2,
    parameter int POOL_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DESTW-1:0]   in_dest,
    input  logic [W-1:0]       in_data,
    output logic               in_stall,
    input  logic [NPORT-1:0]   cong,
    input  logic [NPORT-1:0]   rd_req,
    output logic [NPORT-1:0]   out_valid,
    output logic [NPORT*W-1:0] out_data
);
    logic [NPORT-1:0]   l1_valid, l1_full, l1_pop, l1_push, refill;
    logic [NPORT-1:0]   pool_has, pool_last, spill_mode;
    logic [NPORT*W-1:0] pool_head;
    logic               pool_full, pool_wr;

    tlob_dispatch u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_dest    (in_dest),
        .cong       (cong),
        .rd_req     (rd_req),
        .l1_valid   (l1_valid),
        .l1_full    (l1_full),
        .pool_full  (pool_full),
        .pool_last  (pool_last),
        .in_stall   (in_stall),
        .l1_pop     (l1_pop),
        .l1_push    (l1_push),
        .refill     (refill),
        .pool_wr    (pool_wr),
        .spill_mode (spill_mode)
    );

    tlob_pool #(
        .W     (W),
        .NP    (NPORT),
        .PW    (DESTW),
        .DEPTH (POOL_DEPTH)
    ) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (pool_wr),
        .wr_port   (in_dest),
        .wr_data   (in_data),
        .rd_en     (refill),
        .has_data  (pool_has),
        .last_one  (pool_last),
        .head_data (pool_head),
        .full      (pool_full)
    );

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_l1
            tlob_l1q #(
                .W     (W),
                .DEPTH (L1_DEPTH)
            ) u_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (l1_push[g]),
                .push_data (refill[g] ? pool_head[g*W +: W] : in_data),
                .pop       (l1_pop[g]),
                .valid     (l1_valid[g]),
                .full      (l1_full[g]),
                .head      (out_data[g*W +: W])
            );
        end
    endgenerate

    assign out_valid = l1_valid;

endmodule

// File: rtl/tlob_checker.sv
module tlob_checker #(
    parameter int NP = 5,
    parameter int W  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_stall,
    input logic [NP-1:0]   rd_req,
    input logic [NP-1:0]   out_valid,
    input logic [NP*W-1:0] out_data,
    input logic            pool_full,
    input logic            pool_wr,
    input logic [NP-1:0]   pool_has,
    input logic [NP-1:0]   spill_mode
);
    // R10: backpressure only with an occupied pool and an offered flit
    assert_stall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_stall |-> (pool_full && in_valid));

    // R10: no pool write into a full pool
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pool_wr |-> !pool_full);

    // R6: controller mode agrees with pool contents
    assert_mode_matches_pool_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spill_mode == pool_has);

    // R11: an unread head stays present
    assert_valid_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(out_valid) & ~$past(rd_req) & ~out_valid) == '0));

    generate
        for (genvar k = 0; k < NP; k++) begin : g_hold
            // R11: an unread head keeps its value
            assert_data_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid[k] && !rd_req[k]) |=> $stable(out_data[k*W +: W]));
        end
    endgenerate

endmodule

bind two_level_obuf tlob_checker #(.NP(tlob_pkg::NPORT), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_stall   (in_stall),
    .rd_req     (rd_req),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .pool_full  (pool_full),
    .pool_wr    (pool_wr),
    .pool_has   (pool_has),
    .spill_mode (spill_mode)
);

// File: tb/two_level_obuf_tb.sv
`timescale 1ns/1ps
module two_level_obuf_tb;
    localparam int W = 8;
    localparam int NP = 5;
    localparam int L1D = 2;
    localparam int PD = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_dest = '0;
    logic [W-1:0]  in_data = '0;
    logic          in_stall;
    logic [NP-1:0] cong = '0;
    logic [NP-1:0] rd_req = '0;
    logic [NP-1:0] out_valid;
    logic [NP*W-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [W-1:0] l1m [NP][$];
    logic [W-1:0] sqm [NP][$];

    always #4 clk = ~clk;

    two_level_obuf #(.W(W), .L1_DEPTH(L1D), .POOL_DEPTH(PD)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .in_stall(in_stall), .cong(cong), .rd_req(rd_req),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int pool_total();
        int s = 0;
        for (int o = 0; o < NP; o++) s += sqm[o].size();
        return s;
    endfunction

    task automatic check_outputs(input string tag);
        for (int o = 0; o < NP; o++) begin
            check(tag, $sformatf("out_valid[%0d]", o), int'(out_valid[o]), int'(l1m[o].size() > 0));
            if (l1m[o].size() > 0 && out_valid[o])
                check(tag, $sformatf("out_data[%0d]", o), int'(out_data[o*W +: W]), int'(l1m[o][0]));
        end
    endtask

    // one cycle: drive at negedge, model advances at posedge, compare at next negedge
    task automatic step(input logic v, input logic [2:0] d, input logic [W-1:0] dat,
                        input logic [NP-1:0] cg, input logic [NP-1:0] rd, input string tag);
        bit popv [NP];
        bit refv [NP];
        bit dirv, okd, st;
        in_valid = v; in_dest = d; in_data = dat; cong = cg; rd_req = rd;
        okd  = v && (d < 3'(NP));
        dirv = 1'b0;
        if (okd) dirv = (l1m[d].size() < L1D) && !cg[d] && (sqm[d].size() == 0);
        st = okd && !dirv && (pool_total() == PD);
        for (int o = 0; o < NP; o++) begin
            popv[o] = rd[o] && (l1m[o].size() > 0);
            refv[o] = (sqm[o].size() > 0) && (popv[o] || ((l1m[o].size() < L1D) && !cg[o]));
        end
        #1;
        check(tag, "in_stall", int'(in_stall), int'(st));
        @(posedge clk);
        for (int o = 0; o < NP; o++) begin
            if (popv[o]) void'(l1m[o].pop_front());
            if (refv[o]) l1m[o].push_back(sqm[o].pop_front());
        end
        if (dirv) l1m[d].push_back(dat);
        else if (okd && !st) sqm[d].push_back(dat);
        @(negedge clk);
        check_outputs(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        #1;
        check("R1", "in_stall", int'(in_stall), 0);
        check_outputs("R1");

        // R2 R3: one flit to each output, then invalid codes
        for (int o = 0; o < NP; o++) step(1'b1, 3'(o), 8'(8'h10 + o), '0, '0, "R2_R3");
        step(1'b1, 3'd5, 8'hE5, '0, '0, "R2");
        step(1'b1, 3'd7, 8'hE7, '0, '0, "R2");
        step(1'b0, 3'd0, 8'h00, '0, '0, "R2");

        // R4 R6: overflow East into the pool
        for (int i = 0; i < 4; i++) step(1'b1, 3'd0, 8'(8'h20 + i), '0, '0, "R4_R6");
        // R7: requests to empty or idle outputs have no effect, then drain East
        step(1'b0, 3'd0, 8'h00, '0, 5'b00000, "R7");
        for (int i = 0; i < 6; i++) step(1'b0, 3'd0, 8'h00, '0, 5'b00001, "R7_R8");
        step(1'b0, 3'd0, 8'h00, '0, 5'b00001, "R7");

        // R5: South congested, flits pooled despite space
        step(1'b0, 3'd0, 8'h00, '0, 5'b00010, "R5");
        for (int i = 0; i < 3; i++) step(1'b1, 3'd1, 8'(8'h30 + i), 5'b00010, '0, "R5");
        step(1'b0, 3'd0, 8'h00, 5'b00010, '0, "R5");
        step(1'b0, 3'd0, 8'h00, 5'b00010, 5'b00010, "R5_R8");
        step(1'b0, 3'd0, 8'h00, '0, '0, "R8");
        step(1'b1, 3'd1, 8'h3F, '0, '0, "R6");
        for (int i = 0; i < 5; i++) step(1'b0, 3'd0, 8'h00, '0, 5'b00010, "R6_R8");

        // R10: fill pool through congested West, then probe stall
        for (int i = 0; i < PD; i++) step(1'b1, 3'd2, 8'(8'h40 + i), 5'b00100, '0, "R10");
        step(1'b1, 3'd2, 8'h4F, 5'b00100, '0, "R10");
        step(1'b1, 3'd3, 8'h50, 5'b00100, '0, "R10");
        step(1'b1, 3'd1, 8'h51, 5'b00110, '0, "R10");
        step(1'b1, 3'd6, 8'h52, 5'b00100, '0, "R10_R2");
        // R9: simultaneous reads on several outputs while pool drains
        for (int i = 0; i < 12; i++)
            step(1'b1, 3'd2, 8'(8'h60 + i), '0, 5'b11111, "R9");
        for (int i = 0; i < 10; i++) step(1'b0, 3'd0, 8'h00, '0, 5'b11111, "R9");

        // R6 R9 R11: random traffic, light congestion
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) != 0, 3'($urandom % 6), 8'($urandom),
                 5'($urandom & $urandom & $urandom), 5'($urandom), "R6_R9_R11");
        // R10: random traffic, heavy congestion and few reads
        for (int i = 0; i < 2000; i++)
            step(1'b1, 3'($urandom % 5), 8'($urandom),
                 5'($urandom | $urandom), 5'($urandom & $urandom & $urandom), "R10_R5");
        for (int i = 0; i < 30; i++) step(1'b0, 3'd0, 8'h00, '0, 5'b11111, "R8");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule